// File: doc/BRIEF.md
# Dual-Host Secondary Interrupt Bank

The bank gathers up to 32 interrupt sources of one functional module (24 by default) and reports them to two host request lines that work independently of each other. Every source passes through a two-flop synchronizer. Its 2-bit edge field selects rising, falling, both or no edges, and that field is shared by both hosts. A detected edge sets the source's bit in the status register of each line. Each line has its own status, mask and test-set registers. Each line drives an active-low, registered request that is low while any unmasked status bit is set.

A host reaches the bank through a byte-wide register port. Reads return data combinationally in the same cycle, and reads and writes take effect at the rising clock edge. A control register chooses how status is cleared. In clear-on-read mode, reading a status byte clears the bits it returned. Otherwise the host writes ones to the status byte to clear those bits. The same register chooses whether an edge that arrives while its bit is already set is held back and replayed once the bit has been cleared.

Top module: `irqbank`

## Requirements
- R1: After reset all status bits read 0, every mask byte reads 0xFF, every edge byte reads 0x00, the control register reads 0x00, and both request outputs are high.
- R2: Source i uses edge byte i/4. Bit (i mod 4)*2+1 of that byte enables rising edges and bit (i mod 4)*2 enables falling edges. An enabled edge on the synchronized input sets status bit i on both lines within five clock cycles, and an edge of the other polarity does not.
- R3: A source whose two edge bits are both 0 never sets status on either line, however it toggles.
- R4: The two lines have separate status and mask registers. Clearing, test-setting or masking on one line leaves the other line's registers unchanged.
- R5: The request output of a line (irqN bit 0 for line 0, bit 1 for line 1) is driven low one cycle after a status bit with a mask bit of 0 is set. It is high while every set status bit is masked (mask bit 1 blocks).
- R6: With control bit 0 (clear-on-read) at 0, writing a status byte clears the bits written as 1, and reads do not clear.
- R7: With control bit 0 at 1, reading a status byte clears the bits that read returned, and writes to status are ignored.
- R8: With control bit 1 (pending-disable) at 0, an enabled edge that arrives while its status bit is set is held. The first clear then leaves the bit set and a second clear is needed. With bit 1 at 1, one clear suffices.
- R9: Writing a test-set byte sets the status bits written as 1 on that line only. Test-set bytes read as 0.
- R10: Status bits at positions NSRC and above always read 0, even after a test-set write of ones.
- R11: A clear that lands in the same cycle as a newly detected edge on that bit leaves the bit set.
- R12: Register map, with k the byte index: line-0 status 0x00+k, line-0 mask 0x04+k, line-0 test-set 0x08+k, line-1 status 0x0C+k, line-1 mask 0x10+k, line-1 test-set 0x14+k, edge select 0x18+k, control 0x20 (bit 0 clear-on-read, bit 1 pending-disable). Mask, edge and control read back what was written. Addresses beyond the implemented bytes read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| src | input | NSRC | Asynchronous interrupt source levels |
| regAddr | input | 6 | Register byte address |
| regWr | input | 1 | Write strobe, taken at the rising edge |
| regRd | input | 1 | Read strobe, needed for clear-on-read |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr, combinational |
| irqN | output | 2 | Active-low request per host line |

## Verification
The bench builds the bank with NSRC set to 20. The top status byte is then only half implemented, so the read-as-zero rule for bits 20 to 23 can be seen from a test-set write of 0xFF. The edge register becomes five bytes, and an edge byte write that falls beyond it shows it is ignored. With this source count, a source in the middle of an edge byte (source 13) and sources in the first byte exercise the field packing. Timed stimulus lines a clear up with the exact cycle in which the synchronized edge is detected.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;

  localparam int NLINES = 2;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STAT0,
    RD_MASK0,
    RD_STAT1,
    RD_MASK1,
    RD_EDGE,
    RD_CTRL
  } rdSel_e;

  // Strobes from register decode to the datapath
  typedef struct packed {
    logic [NLINES-1:0] statWr;
    logic [NLINES-1:0] statRd;
    logic [NLINES-1:0] maskWr;
    logic [NLINES-1:0] testWr;
    logic              edgeWr;
    rdSel_e            rdSel;
    logic [2:0]        byteIdx;
    logic [7:0]        data;
    logic              clrOnRead;
    logic              pendDis;
  } strobes_t;

endpackage

// File: rtl/irqbank_ctrl.sv
module irqbank_ctrl
  import irqbank_pkg::*;
#(
  parameter int NSRC = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regWdata,
  output strobes_t   stb
);

  localparam int NBYTES = (NSRC + 7) / 8;
  localparam int EBYTES = (2 * NSRC + 7) / 8;
  localparam logic [5:0] CTRL_ADDR = 6'h20;

  logic cfgCor;
  logic cfgPend;
  logic lowOk;
  logic edgeOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgCor  <= 1'b0;
      cfgPend <= 1'b0;
    end else if (regWr && regAddr == CTRL_ADDR) begin
      cfgCor  <= regWdata[0];
      cfgPend <= regWdata[1];
    end
  end

  always_comb begin
    lowOk  = int'(regAddr[1:0]) < NBYTES;
    edgeOk = int'(regAddr[2:0]) < EBYTES;
    stb           = '0;
    stb.data      = regWdata;
    stb.clrOnRead = cfgCor;
    stb.pendDis   = cfgPend;
    stb.rdSel     = RD_NONE;
    stb.byteIdx   = {1'b0, regAddr[1:0]};
    case (regAddr[5:2])
      4'd0: if (lowOk) begin
        stb.rdSel     = RD_STAT0;
        stb.statWr[0] = regWr;
        stb.statRd[0] = regRd;
      end
      4'd1: if (lowOk) begin
        stb.rdSel     = RD_MASK0;
        stb.maskWr[0] = regWr;
      end
      4'd2: if (lowOk) stb.testWr[0] = regWr;
      4'd3: if (lowOk) begin
        stb.rdSel     = RD_STAT1;
        stb.statWr[1] = regWr;
        stb.statRd[1] = regRd;
      end
      4'd4: if (lowOk) begin
        stb.rdSel     = RD_MASK1;
        stb.maskWr[1] = regWr;
      end
      4'd5: if (lowOk) stb.testWr[1] = regWr;
      4'd6, 4'd7: if (edgeOk) begin
        stb.byteIdx = regAddr[2:0];
        stb.rdSel   = RD_EDGE;
        stb.edgeWr  = regWr;
      end
      4'd8: if (regAddr[1:0] == 2'd0) stb.rdSel = RD_CTRL;
      default: stb.rdSel = RD_NONE;
    endcase
  end

  // R12
  write_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.statWr, stb.maskWr, stb.testWr, stb.edgeWr}));

  // R12
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == CTRL_ADDR) |=> ({stb.pendDis, stb.clrOnRead} == $past(regWdata[1:0])));

endmodule

// File: rtl/irqbank_dp.sv
module irqbank_dp
  import irqbank_pkg::*;
#(
  parameter int NSRC = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   src,
  input  strobes_t          stb,
  output logic [7:0]        regRdata,
  output logic [NLINES-1:0] irqN
);

  localparam int NBYTES = (NSRC + 7) / 8;
  localparam int EBYTES = (2 * NSRC + 7) / 8;
  localparam int SW = NBYTES * 8;
  localparam int EW = EBYTES * 8;
  localparam logic [63:0] ONES64 = '1;
  localparam logic [SW-1:0] VALID  = ONES64[SW-1:0] >> (SW - NSRC);
  localparam logic [EW-1:0] EVALID = ONES64[EW-1:0] >> (EW - 2 * NSRC);

  logic [NSRC-1:0] sync1, sync2, prev, hit;
  logic [SW-1:0]   hitW, laneData, laneSel;
  logic [EW-1:0]   edgeCfg, eData, eSel;

  logic [NLINES-1:0][SW-1:0] stat, mask, pend;
  logic [NLINES-1:0][SW-1:0] setV, clrV, statNext, pendNext, maskNext;
  logic [NLINES-1:0]         irqNext;

  // Synchronizer and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= src;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  // Per-source edge qualification
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = (sync2[i] & ~prev[i] & edgeCfg[2*i+1]) |
                    (~sync2[i] & prev[i] & edgeCfg[2*i]);
  end

  assign hitW     = SW'(hit);
  assign laneData = SW'(stb.data) << (8 * stb.byteIdx);
  assign laneSel  = SW'(8'hFF) << (8 * stb.byteIdx);
  assign eData    = EW'(stb.data) << (8 * stb.byteIdx);
  assign eSel     = EW'(8'hFF) << (8 * stb.byteIdx);

  always_comb begin
    for (int l = 0; l < NLINES; l++) begin
      setV[l] = (hitW | (stb.testWr[l] ? laneData : '0)) & VALID;
      if (stb.statWr[l] && !stb.clrOnRead)
        clrV[l] = laneData;
      else if (stb.statRd[l] && stb.clrOnRead)
        clrV[l] = stat[l] & laneSel;
      else
        clrV[l] = '0;
      // A held edge keeps the bit set through one clear
      statNext[l] = ((stat[l] & ~clrV[l]) | setV[l] | (clrV[l] & pend[l])) & VALID;
      pendNext[l] = stb.pendDis ? '0 :
                    (((pend[l] & ~clrV[l]) | (hitW & stat[l] & ~clrV[l])) & VALID);
      maskNext[l] = stb.maskWr[l] ? ((mask[l] & ~laneSel) | laneData) : mask[l];
      irqNext[l]  = ~|(stat[l] & ~mask[l]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stat    <= '0;
      pend    <= '0;
      mask    <= '1;
      irqN    <= '1;
      edgeCfg <= '0;
    end else begin
      stat <= statNext;
      pend <= pendNext;
      mask <= maskNext;
      irqN <= irqNext;
      if (stb.edgeWr) edgeCfg <= ((edgeCfg & ~eSel) | eData) & EVALID;
    end
  end

  // Read mux
  always_comb begin
    regRdata = 8'h00;
    case (stb.rdSel)
      RD_STAT0, RD_STAT1, RD_MASK0, RD_MASK1: begin
        for (int b = 0; b < NBYTES; b++) begin
          if (32'(stb.byteIdx) == b) begin
            case (stb.rdSel)
              RD_STAT0: regRdata = stat[0][b*8 +: 8];
              RD_STAT1: regRdata = stat[1][b*8 +: 8];
              RD_MASK0: regRdata = mask[0][b*8 +: 8];
              default:  regRdata = mask[1][b*8 +: 8];
            endcase
          end
        end
      end
      RD_EDGE: begin
        for (int b = 0; b < EBYTES; b++)
          if (32'(stb.byteIdx) == b) regRdata = edgeCfg[b*8 +: 8];
      end
      RD_CTRL: regRdata = {6'b0, stb.pendDis, stb.clrOnRead};
      default: regRdata = 8'h00;
    endcase
  end

  for (genvar gl = 0; gl < NLINES; gl++) begin : g_chk
    // R2
    edge_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
      (|hit) |=> ((stat[gl] & SW'($past(hit))) == SW'($past(hit))));

    // R3
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stat[gl] & ~$past(stat[gl]) & ~$past(setV[gl])) == '0);

    // R6
    read_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.statRd[gl] && !stb.clrOnRead && !stb.statWr[gl]) |=>
        (($past(stat[gl]) & ~stat[gl]) == '0));

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pend[gl] & ~stat[gl]) == '0);

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
      !irqN[gl] |-> $past(|stat[gl]));
  end

endmodule

// File: rtl/irqbank.sv
module irqbank
  import irqbank_pkg::*;
#(
  parameter int NSRC = 24
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] src,
  input  logic [5:0]      regAddr,
  input  logic            regWr,
  input  logic            regRd,
  input  logic [7:0]      regWdata,
  output logic [7:0]      regRdata,
  output logic [1:0]      irqN
);

  strobes_t stb;

  irqbank_ctrl #(.NSRC(NSRC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWr    (regWr),
    .regRd    (regRd),
    .regWdata (regWdata),
    .stb      (stb)
  );

  irqbank_dp #(.NSRC(NSRC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .src      (src),
    .stb      (stb),
    .regRdata (regRdata),
    .irqN     (irqN)
  );

endmodule

// File: tb/irqbank_tb.sv
module irqbank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 20;
  localparam int NVEC = 24;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic [5:0]      regAddr = '0;
  logic            regWr = 1'b0;
  logic            regRd = 1'b0;
  logic [7:0]      regWdata = '0;
  logic [7:0]      regRdata;
  logic [1:0]      irqN;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  irqbank #(.NSRC(NSRC)) u_dut (
    .clk(clk), .rstN(rstN), .src(src), .regAddr(regAddr), .regWr(regWr),
    .regRd(regRd), .regWdata(regWdata), .regRdata(regRdata), .irqN(irqN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {isWrite, addr, data, expected, requirement}
  localparam logic [26:0] VECS [0:NVEC-1] = '{
    {1'b0, 6'h00, 8'h00, 8'h00, 4'd1},   // R1 status line 0
    {1'b0, 6'h0E, 8'h00, 8'h00, 4'd1},   // R1 status line 1
    {1'b0, 6'h06, 8'h00, 8'hFF, 4'd1},   // R1 mask
    {1'b0, 6'h1C, 8'h00, 8'h00, 4'd1},   // R1 edge
    {1'b0, 6'h20, 8'h00, 8'h00, 4'd1},   // R1 control
    {1'b1, 6'h05, 8'hA5, 8'h00, 4'd12},
    {1'b0, 6'h05, 8'h00, 8'hA5, 4'd12},  // R12 mask readback
    {1'b1, 6'h10, 8'h3C, 8'h00, 4'd4},
    {1'b0, 6'h10, 8'h00, 8'h3C, 4'd4},   // R4 line-1 mask
    {1'b0, 6'h04, 8'h00, 8'hFF, 4'd4},   // R4 line-0 mask untouched
    {1'b1, 6'h1A, 8'h96, 8'h00, 4'd12},
    {1'b0, 6'h1A, 8'h00, 8'h96, 4'd12},  // R12 edge readback
    {1'b1, 6'h1D, 8'hFF, 8'h00, 4'd12},
    {1'b0, 6'h1D, 8'h00, 8'h00, 4'd12},  // R12 edge byte beyond range
    {1'b1, 6'h0A, 8'hFF, 8'h00, 4'd9},
    {1'b0, 6'h02, 8'h00, 8'h0F, 4'd10},  // R10 bits above NSRC read zero
    {1'b0, 6'h0A, 8'h00, 8'h00, 4'd9},   // R9 test-set reads zero
    {1'b0, 6'h0E, 8'h00, 8'h00, 4'd4},   // R4 other line not set
    {1'b1, 6'h02, 8'hFF, 8'h00, 4'd6},
    {1'b0, 6'h02, 8'h00, 8'h00, 4'd6},   // R6 write-one clear
    {1'b1, 6'h20, 8'h03, 8'h00, 4'd12},
    {1'b0, 6'h20, 8'h00, 8'h03, 4'd12},  // R12 control readback
    {1'b1, 6'h20, 8'h00, 8'h00, 4'd12},
    {1'b0, 6'h03, 8'h00, 8'h00, 4'd12}   // R12 unimplemented status byte
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic readCheck(input string tag, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] v;
    regRead(a, v);
    check(tag, v, exp);
  endtask

  task automatic setSrc(input int idx, input logic val);
    @(negedge clk);
    src[idx] = val;
    repeat (5) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irqN", {6'b0, irqN}, 8'h03);

    for (int n = 0; n < NVEC; n++) begin
      if (VECS[n][26]) regWrite(VECS[n][25:20], VECS[n][19:12]);
      else begin
        regRead(VECS[n][25:20], v);
        checks++;
        if (v !== VECS[n][11:4]) begin
          errors++;
          $display("FAIL R%0d vector %0d actual=%02h expected=%02h",
                   VECS[n][3:0], n, v, VECS[n][11:4]);
        end
      end
    end
    regWrite(6'h05, 8'hFF);
    regWrite(6'h10, 8'hFF);
    regWrite(6'h1A, 8'h00);

    // R2 source 13: edge byte 3, rising bit 3
    regWrite(6'h1B, 8'h08);
    setSrc(13, 1'b1);
    readCheck("R2 rising line0", 6'h01, 8'h20);
    readCheck("R4 rising line1", 6'h0D, 8'h20);
    readCheck("R6 read does not clear", 6'h0D, 8'h20);
    check("R5 masked irqN", {6'b0, irqN}, 8'h03);
    regWrite(6'h05, 8'hDF);
    repeat (2) @(negedge clk);
    check("R5 unmasked irqN", {6'b0, irqN}, 8'h02);
    regWrite(6'h01, 8'h20);
    readCheck("R6 line0 cleared", 6'h01, 8'h00);
    readCheck("R4 line1 kept", 6'h0D, 8'h20);
    repeat (2) @(negedge clk);
    check("R5 irqN released", {6'b0, irqN}, 8'h03);
    regWrite(6'h0D, 8'h20);
    regWrite(6'h05, 8'hFF);
    setSrc(13, 1'b0);
    readCheck("R2 falling ignored", 6'h01, 8'h00);

    // R2 falling only
    regWrite(6'h1B, 8'h04);
    setSrc(13, 1'b1);
    readCheck("R2 rising ignored", 6'h01, 8'h00);
    setSrc(13, 1'b0);
    readCheck("R2 falling detected", 6'h01, 8'h20);
    regWrite(6'h01, 8'h20);
    regWrite(6'h0D, 8'h20);
    regWrite(6'h1B, 8'h00);

    // R3 source 0 with edge field 00
    setSrc(0, 1'b1);
    setSrc(0, 1'b0);
    readCheck("R3 disabled line0", 6'h00, 8'h00);
    readCheck("R3 disabled line1", 6'h0C, 8'h00);

    // R8 source 1: edge byte 0 rising bit 3, buffering on
    regWrite(6'h18, 8'h08);
    setSrc(1, 1'b1);
    setSrc(1, 1'b0);
    setSrc(1, 1'b1);
    regWrite(6'h00, 8'h02);
    readCheck("R8 held edge re-sets", 6'h00, 8'h02);
    regWrite(6'h00, 8'h02);
    readCheck("R8 second clear", 6'h00, 8'h00);
    regWrite(6'h0C, 8'h02);
    regWrite(6'h0C, 8'h02);
    readCheck("R8 line1 cleared", 6'h0C, 8'h00);
    regWrite(6'h20, 8'h02);
    setSrc(1, 1'b0);
    setSrc(1, 1'b1);
    setSrc(1, 1'b0);
    setSrc(1, 1'b1);
    regWrite(6'h00, 8'h02);
    readCheck("R8 no buffering", 6'h00, 8'h00);
    regWrite(6'h0C, 8'h02);
    regWrite(6'h18, 8'h00);

    // R7 clear-on-read
    regWrite(6'h20, 8'h01);
    regWrite(6'h08, 8'h81);
    readCheck("R7 first read", 6'h00, 8'h81);
    readCheck("R7 cleared by read", 6'h00, 8'h00);
    regWrite(6'h08, 8'h01);
    regWrite(6'h00, 8'hFF);
    readCheck("R7 write ignored", 6'h00, 8'h01);
    readCheck("R7 cleared again", 6'h00, 8'h00);

    // R9 test-set on line 1 only
    regWrite(6'h15, 8'h40);
    readCheck("R9 line0 untouched", 6'h01, 8'h00);
    readCheck("R9 line1 forced", 6'h0D, 8'h40);
    readCheck("R9 line1 cleared", 6'h0D, 8'h00);

    // R11 clear in the detection cycle, source 2 rising = edge byte 0 bit 5
    regWrite(6'h20, 8'h02);
    regWrite(6'h18, 8'h20);
    regWrite(6'h08, 8'h04);
    @(negedge clk);
    src[2] = 1'b1;
    @(negedge clk);
    regWrite(6'h00, 8'h04);
    readCheck("R11 edge wins over clear", 6'h00, 8'h04);
    regWrite(6'h00, 8'h04);
    readCheck("R11 later clear", 6'h00, 8'h00);

    finishRun();
  end

endmodule